// File: doc/BRIEF.md
# Five-Port Mesh Router with Dimension-Ordered Routing

This block is one router of a two-dimensional on-chip mesh. It has five ports: one that injects and ejects traffic for the attached engine, and four that link to the neighbouring routers on the north, south, east and west sides. Traffic moves as 72-bit flits. Each input port holds two independent lanes, one per virtual channel, and each lane has a small FIFO. The router reads the destination coordinates in a packet's first flit and compares them with its own position, which is fixed by parameters. It sends the packet along the X axis until the column matches, then along the Y axis, and delivers the packet to the local port once both coordinates match.

The router uses wormhole switching. The first flit of a packet claims an output port, the middle flits follow it through, and the last flit frees the port. When several packet starts compete for a free output, the local injection lanes win. Otherwise a rotating pointer shares the output fairly. Flow control is space-based: an output moves a flit only while the downstream lane for that flit's outgoing channel reports free room. Each input reports the room in its own lanes the same way, so no flit is ever lost. A flit written into an idle router leaves on the next cycle.

Top module: `mesh_router`

## Requirements
- R1: A flit is 72 bits: kind in [71:68], destination X in [67:64], destination Y in [63:60], channel in [59:58] (value 0 or 1), payload in [57:0]. The kind codes are 1 = packet start, 2 = middle, 3 = packet end, 4 = one-flit packet.
- R2: A starting flit (kind 1 or 4) goes east (port 3) if its X is greater than the router's X, and west (port 4) if it is smaller. When the X values are equal, it goes north (port 1) if its Y is greater, south (port 2) if its Y is smaller, and local (port 0) if both match. Middle and end flits follow the port their packet's start took.
- R3: A flit leaves on channel 0 from the east and west ports and on channel 1 from the north and south ports. At the local port it keeps its incoming channel. All other fields are passed through unchanged.
- R4: A flit written into an empty lane whose target output is free and has room appears on that output in the cycle after it is accepted.
- R5: Each input lane (port, channel) holds BUF_DEPTH flits (default 4). Its in_space bit is low while the lane is full. A flit offered to a full lane is ignored and never reaches any output.
- R6: An output never presents a flit while the out_space bit for that flit's outgoing channel is low. Such flits wait and are not dropped.
- R7: Once a packet start (kind 1) leaves an output, that output carries only this packet's flits until its end flit (kind 3) has left.
- R8: When a free output has competing packet starts and one of them is on the local input, the local input wins.
- R9: Among competing non-local inputs, packets are granted round-robin. The scan order is port-major (port*2 + channel), and after reset the lowest index is served first.
- R10: Flits from one input lane leave in the order they arrived.
- R11: During reset, no output is valid and every in_space bit is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 5 | Per-input flit strobe, indexed 0 local, 1 north, 2 south, 3 east, 4 west |
| in_flit | input | 5x72 | Per-input flit |
| in_space | output | 5x2 | Free room per input port and channel |
| out_valid | output | 5 | Per-output flit strobe |
| out_flit | output | 5x72 | Per-output flit |
| out_space | input | 5x2 | Downstream room per output port and channel |

## Verification
The hardest case to reach is several complete packets contending for one output at the same moment. From the ports, traffic normally arrives staggered, so the first start flit simply takes a free output. The bench therefore holds the target output's out_space low while it loads whole packets into the local, north and south lanes, then releases it. This forces the grant order, packet integrity and round-robin alternation to resolve in a single, known state. A reset before each contention case places the rotating pointer at a known position. A lane-fill case holds an output back until the source lane is full, then offers one more flit to confirm that it disappears.

// File: rtl/mrt_pkg.sv
package mrt_pkg;
  localparam int FLIT_W = 72;
  localparam int NPORT  = 5;
  localparam int NVC    = 2;
  localparam int NREQ   = NPORT * NVC;
  localparam int PW     = 3;

  localparam logic [PW-1:0] P_LOCAL = 3'd0;
  localparam logic [PW-1:0] P_NORTH = 3'd1;
  localparam logic [PW-1:0] P_SOUTH = 3'd2;
  localparam logic [PW-1:0] P_EAST  = 3'd3;
  localparam logic [PW-1:0] P_WEST  = 3'd4;

  typedef enum logic [3:0] {
    K_START  = 4'd1,
    K_MIDDLE = 4'd2,
    K_END    = 4'd3,
    K_SOLO   = 4'd4
  } kind_e;

  function automatic logic [3:0] f_kind(input logic [FLIT_W-1:0] f);
    return f[71:68];
  endfunction

  function automatic logic [3:0] f_dx(input logic [FLIT_W-1:0] f);
    return f[67:64];
  endfunction

  function automatic logic [3:0] f_dy(input logic [FLIT_W-1:0] f);
    return f[63:60];
  endfunction

  function automatic logic [1:0] f_vc(input logic [FLIT_W-1:0] f);
    return f[59:58];
  endfunction

  function automatic logic opens_pkt(input logic [3:0] k);
    return (k == K_START) || (k == K_SOLO);
  endfunction

  function automatic logic closes_pkt(input logic [3:0] k);
    return (k == K_END) || (k == K_SOLO);
  endfunction

  // dimension-ordered choice: X axis first, then Y, then eject
  function automatic logic [PW-1:0] xy_route(input logic [3:0] dx, input logic [3:0] dy,
                                             input logic [3:0] mx, input logic [3:0] my);
    if (dx > mx)      return P_EAST;
    else if (dx < mx) return P_WEST;
    else if (dy > my) return P_NORTH;
    else if (dy < my) return P_SOUTH;
    else              return P_LOCAL;
  endfunction

  // outgoing channel: X links use 0, Y links use 1, ejection keeps the incoming one
  function automatic logic pick_vc(input logic [PW-1:0] port, input logic vc_in);
    if (port == P_EAST || port == P_WEST)        return 1'b0;
    else if (port == P_NORTH || port == P_SOUTH) return 1'b1;
    else                                         return vc_in;
  endfunction

  function automatic logic [FLIT_W-1:0] with_vc(input logic [FLIT_W-1:0] f, input logic vc);
    logic [FLIT_W-1:0] g;
    g = f;
    g[59:58] = {1'b0, vc};
    return g;
  endfunction
endpackage

// File: rtl/mrt_fifo.sv
module mrt_fifo #(
  parameter int W     = 72,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         rd,
  output logic [W-1:0] rdata,
  output logic         not_empty,
  output logic         has_space
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          do_wr, do_rd;

  assign not_empty = (cnt_q != '0);
  assign has_space = (cnt_q != CW'(DEPTH));
  assign do_wr     = wr && has_space;
  assign do_rd     = rd && not_empty;
  assign rdata     = mem[rp_q];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp_q] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_wr) wp_q <= bump(wp_q);
      if (do_rd) rp_q <= bump(rp_q);
      case ({do_wr, do_rd})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/mrt_out_alloc.sv
module mrt_out_alloc #(
  parameter int NR   = 10,
  parameter int NLOC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NR-1:0] req,
  input  logic [NR-1:0] start,
  input  logic [NR-1:0] fin,
  output logic [NR-1:0] grant,
  output logic          locked
);
  localparam int IW = $clog2(NR);

  logic          locked_q, found;
  logic [IW-1:0] owner_q, ptr_q, win;

  always_comb begin
    grant = '0;
    found = 1'b0;
    win   = '0;
    if (locked_q) begin
      if (req[owner_q]) grant[owner_q] = 1'b1;
    end else begin
      // injection lanes first, then rotate from the pointer
      for (int i = 0; i < NLOC; i++) begin
        if (!found && req[i] && start[i]) begin
          found = 1'b1;
          win   = IW'(i);
        end
      end
      for (int k = 0; k < NR; k++) begin
        if (!found && req[(int'(ptr_q) + k) % NR] && start[(int'(ptr_q) + k) % NR]) begin
          found = 1'b1;
          win   = IW'((int'(ptr_q) + k) % NR);
        end
      end
      if (found) grant[win] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked_q <= 1'b0;
      owner_q  <= '0;
      ptr_q    <= '0;
    end else if (!locked_q) begin
      if (found) begin
        ptr_q <= (int'(win) == NR - 1) ? '0 : win + 1'b1;
        if (!fin[win]) begin
          locked_q <= 1'b1;
          owner_q  <= win;
        end
      end
    end else if (req[owner_q] && fin[owner_q]) begin
      locked_q <= 1'b0;
    end
  end

  assign locked = locked_q;
endmodule

// File: rtl/mesh_router.sv
module mesh_router
  import mrt_pkg::*;
#(
  parameter logic [3:0] MY_X      = 4'd2,
  parameter logic [3:0] MY_Y      = 4'd2,
  parameter int         BUF_DEPTH = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [NPORT-1:0]                  in_valid,
  input  logic [NPORT-1:0][FLIT_W-1:0]      in_flit,
  output logic [NPORT-1:0][NVC-1:0]         in_space,
  output logic [NPORT-1:0]                  out_valid,
  output logic [NPORT-1:0][FLIT_W-1:0]      out_flit,
  input  logic [NPORT-1:0][NVC-1:0]         out_space
);
  logic [NREQ-1:0]              hv, ok, pop, st, fn, ovc;
  logic [NREQ-1:0][FLIT_W-1:0]  head;
  logic [NREQ-1:0][PW-1:0]      tgt, cur_q;
  logic [NPORT-1:0][NREQ-1:0]   req, gnt;
  logic [NPORT-1:0]             out_lock;

  // input lanes, one FIFO per (port, channel); lane index = port*NVC + channel
  for (genvar p = 0; p < NPORT; p++) begin : g_in
    for (genvar v = 0; v < NVC; v++) begin : g_vc
      mrt_fifo #(.W(FLIT_W), .DEPTH(BUF_DEPTH)) u_lane (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (in_valid[p] && (f_vc(in_flit[p]) == 2'(v))),
        .wdata     (in_flit[p]),
        .rd        (pop[p*NVC+v]),
        .rdata     (head[p*NVC+v]),
        .not_empty (hv[p*NVC+v]),
        .has_space (in_space[p][v])
      );
    end
  end

  // per-lane target and eligibility
  always_comb begin
    for (int r = 0; r < NREQ; r++) begin
      st[r]  = opens_pkt(f_kind(head[r]));
      fn[r]  = closes_pkt(f_kind(head[r]));
      tgt[r] = st[r] ? xy_route(f_dx(head[r]), f_dy(head[r]), MY_X, MY_Y) : cur_q[r];
      ovc[r] = pick_vc(tgt[r], head[r][58]);
      ok[r]  = hv[r] && out_space[tgt[r]][ovc[r]];
    end
    for (int o = 0; o < NPORT; o++) begin
      for (int r = 0; r < NREQ; r++) begin
        req[o][r] = ok[r] && (tgt[r] == PW'(o));
      end
    end
  end

  for (genvar o = 0; o < NPORT; o++) begin : g_out
    mrt_out_alloc #(.NR(NREQ), .NLOC(NVC)) u_alloc (
      .clk    (clk),
      .rst_n  (rst_n),
      .req    (req[o]),
      .start  (st),
      .fin    (fn),
      .grant  (gnt[o]),
      .locked (out_lock[o])
    );
  end

  // switch traversal
  always_comb begin
    pop = '0;
    for (int o = 0; o < NPORT; o++) begin
      out_valid[o] = |gnt[o];
      out_flit[o]  = '0;
      for (int r = 0; r < NREQ; r++) begin
        if (gnt[o][r]) begin
          out_flit[o] = with_vc(head[r], ovc[r]);
          pop[r]      = 1'b1;
        end
      end
    end
  end

  // remember the port each lane's current packet took
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= '0;
    end else begin
      for (int r = 0; r < NREQ; r++) begin
        if (pop[r] && st[r]) cur_q[r] <= tgt[r];
      end
    end
  end
endmodule

// File: rtl/mrt_router_chk.sv
module mrt_router_chk
  import mrt_pkg::*;
#(
  parameter logic [3:0] MY_X = 4'd2,
  parameter logic [3:0] MY_Y = 4'd2
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [NPORT-1:0][NVC-1:0]    in_space,
  input logic [NPORT-1:0]             out_valid,
  input logic [NPORT-1:0][FLIT_W-1:0] out_flit,
  input logic [NPORT-1:0][NVC-1:0]    out_space,
  input logic [NPORT-1:0]             out_lock
);
  always @(posedge clk) begin
    if (!rst_n) begin
      a_r11_reset_idle: assert ((&in_space) && (out_valid == '0))
        else $error("R11 outputs not idle in reset");
    end
  end

  for (genvar o = 0; o < NPORT; o++) begin : g_chk
    a_r6_room_held: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid[o] |-> out_space[o][out_flit[o][58]]);

    a_r2_xy_port: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid[o] && opens_pkt(f_kind(out_flit[o])))
        |-> (xy_route(f_dx(out_flit[o]), f_dy(out_flit[o]), MY_X, MY_Y) == PW'(o)));

    a_r7_claim: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid[o] && f_kind(out_flit[o]) == K_START) |=> out_lock[o]);

    a_r7_no_cut_in: assert property (@(posedge clk) disable iff (!rst_n)
      (out_lock[o] && out_valid[o]) |-> !opens_pkt(f_kind(out_flit[o])));

    if (o == 3 || o == 4) begin : g_x
      a_r3_x_lane: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid[o] |-> (f_vc(out_flit[o]) == 2'd0));
    end else if (o == 1 || o == 2) begin : g_y
      a_r3_y_lane: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid[o] |-> (f_vc(out_flit[o]) == 2'd1));
    end
  end
endmodule

bind mesh_router mrt_router_chk #(.MY_X(MY_X), .MY_Y(MY_Y)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_space  (in_space),
  .out_valid (out_valid),
  .out_flit  (out_flit),
  .out_space (out_space),
  .out_lock  (out_lock)
);

// File: tb/mesh_router_tb_top.sv
module mesh_router_tb_top;
  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic [4:0]          in_valid = '0;
  logic [4:0][71:0]    in_flit = '0;
  logic [4:0][1:0]     in_space;
  logic [4:0]          out_valid;
  logic [4:0][71:0]    out_flit;
  logic [4:0][1:0]     out_space = '1;

  int  n_chk  = 0;
  int  n_bad  = 0;
  bit  done   = 1'b0;

  logic [71:0] exp_q [5][$];
  string       tag_q [5][$];

  always #10 clk = ~clk;

  mesh_router #(.MY_X(4'd2), .MY_Y(4'd2), .BUF_DEPTH(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_flit(in_flit),
    .in_space(in_space), .out_valid(out_valid), .out_flit(out_flit),
    .out_space(out_space)
  );

  function automatic logic [71:0] mk(input logic [3:0] k, input logic [3:0] x,
                                     input logic [3:0] y, input logic vc,
                                     input logic [57:0] pl);
    return {k, x, y, 1'b0, vc, pl};
  endfunction

  function automatic logic [71:0] revc(input logic [71:0] f, input logic vc);
    logic [71:0] g;
    g = f;
    g[59:58] = {1'b0, vc};
    return g;
  endfunction

  task automatic chk(input string rq, input logic [71:0] act, input logic [71:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic expect_out(input int o, input logic [71:0] f, input string rq);
    exp_q[o].push_back(f);
    tag_q[o].push_back(rq);
  endtask

  task automatic send(input int p, input logic [71:0] f);
    @(posedge clk); #2;
    in_valid[p] = 1'b1;
    in_flit[p]  = f;
    @(posedge clk); #2;
    in_valid[p] = 1'b0;
  endtask

  task automatic drain_check(input string rq);
    for (int o = 0; o < 5; o++) begin
      chk(rq, 72'(exp_q[o].size()), 72'd0);
      exp_q[o].delete();
      tag_q[o].delete();
    end
  endtask

  task automatic do_reset();
    @(posedge clk); #2;
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R11 in_space in reset", 72'(in_space), 72'h3ff);
    chk("R11 out_valid in reset", 72'(out_valid), 72'd0);
    @(posedge clk); #2;
    rst_n = 1'b1;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      for (int o = 0; o < 5; o++) begin
        if (out_valid[o]) begin
          if (exp_q[o].size() == 0) begin
            n_chk++;
            n_bad++;
            $display("FAIL R5/R10 unexpected flit on port %0d actual=%h expected=none", o, out_flit[o]);
          end else begin
            chk(tag_q[o].pop_front(), out_flit[o], exp_q[o].pop_front());
          end
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [71:0] f;
    do_reset();

    // R4: single flit local -> east, one cycle through
    f = mk(4'd4, 4'd3, 4'd2, 1'b0, 58'h1234);
    expect_out(3, revc(f, 1'b0), "R4 latency");
    @(posedge clk); #2;
    in_valid[0] = 1'b1; in_flit[0] = f;
    @(negedge clk);
    chk("R4 not yet out", 72'(out_valid[3]), 72'd0);
    @(posedge clk); #2;
    in_valid[0] = 1'b0;
    @(negedge clk);
    chk("R4 valid next cycle", 72'(out_valid[3]), 72'd1);
    repeat (3) @(posedge clk);

    // R2/R3/R1: routing and channel rewrite
    f = mk(4'd4, 4'd3, 4'd0, 1'b1, 58'hA1); expect_out(3, revc(f, 1'b0), "R2 east x-first");   send(0, f);
    f = mk(4'd4, 4'd1, 4'd2, 1'b1, 58'hA2); expect_out(4, revc(f, 1'b0), "R2 west");          send(0, f);
    f = mk(4'd4, 4'd2, 4'd3, 1'b0, 58'hA3); expect_out(1, revc(f, 1'b1), "R3 north vc1");     send(0, f);
    f = mk(4'd4, 4'd2, 4'd0, 1'b0, 58'hA4); expect_out(2, revc(f, 1'b1), "R3 south vc1");     send(0, f);
    f = mk(4'd4, 4'd2, 4'd2, 1'b1, 58'hA5); expect_out(0, f,             "R3 local keeps vc"); send(0, f);
    f = mk(4'd4, 4'd0, 4'd7, 1'b0, 58'hA6); expect_out(4, revc(f, 1'b0), "R2 east in to west"); send(3, f);
    f = mk(4'd4, 4'd2, 4'd2, 1'b0, 58'hA7); expect_out(0, f,             "R2 north in eject"); send(1, f);
    repeat (4) @(posedge clk);
    drain_check("R2 all routed");

    // R7/R8: local beats others; packets never interleave
    do_reset();
    out_space[3] = 2'b00;
    f = mk(4'd1, 4'd3, 4'd2, 1'b0, 58'hB0); expect_out(3, f, "R8 local first");   send(0, f);
    f = mk(4'd3, 4'd3, 4'd2, 1'b0, 58'hB1); expect_out(3, f, "R8 local tail");    send(0, f);
    f = mk(4'd1, 4'd3, 4'd1, 1'b0, 58'hC0); expect_out(3, f, "R7 north start");   send(1, f);
    f = mk(4'd2, 4'd0, 4'd0, 1'b0, 58'hC1); expect_out(3, f, "R7 north middle");  send(1, f);
    f = mk(4'd3, 4'd0, 4'd0, 1'b0, 58'hC2); expect_out(3, f, "R7 north end");     send(1, f);
    f = mk(4'd1, 4'd5, 4'd3, 1'b0, 58'hD0); expect_out(3, f, "R7 south start");   send(2, f);
    f = mk(4'd2, 4'd0, 4'd0, 1'b0, 58'hD1); expect_out(3, f, "R7 south middle");  send(2, f);
    f = mk(4'd3, 4'd0, 4'd0, 1'b0, 58'hD2); expect_out(3, f, "R7 south end");     send(2, f);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R6 held while no room", 72'(out_valid[3]), 72'd0);
    end
    @(posedge clk); #2;
    out_space[3] = 2'b11;
    repeat (12) @(posedge clk);
    drain_check("R7 packets drained");

    // R9: round-robin between north and south
    do_reset();
    out_space[3] = 2'b00;
    for (int i = 0; i < 3; i++) begin
      f = mk(4'd4, 4'd4, 4'd2, 1'b0, 58'(16'hE000 + i)); send(1, f);
      f = mk(4'd4, 4'd4, 4'd2, 1'b0, 58'(16'hF000 + i)); send(2, f);
    end
    for (int i = 0; i < 3; i++) begin
      expect_out(3, mk(4'd4, 4'd4, 4'd2, 1'b0, 58'(16'hE000 + i)), "R9 north turn");
      expect_out(3, mk(4'd4, 4'd4, 4'd2, 1'b0, 58'(16'hF000 + i)), "R9 south turn");
    end
    @(posedge clk); #2;
    out_space[3] = 2'b11;
    repeat (10) @(posedge clk);
    drain_check("R9 alternation drained");

    // R5/R10/R6: fill a west lane aimed north, offer one extra
    do_reset();
    out_space[1] = 2'b00;
    for (int i = 0; i < 4; i++) begin
      f = mk(4'd4, 4'd2, 4'd6, 1'b0, 58'(16'h7700 + i));
      expect_out(1, revc(f, 1'b1), "R10 lane order");
      send(4, f);
    end
    @(negedge clk);
    chk("R5 full lane no space", 72'(in_space[4][0]), 72'd0);
    chk("R5 other lane has space", 72'(in_space[4][1]), 72'd1);
    send(4, mk(4'd4, 4'd2, 4'd6, 1'b0, 58'h7799));
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R6 north held", 72'(out_valid[1]), 72'd0);
    end
    @(posedge clk); #2;
    out_space[1] = 2'b11;
    repeat (10) @(posedge clk);
    @(negedge clk);
    chk("R5 space back after drain", 72'(in_space[4][0]), 72'd1);
    drain_check("R5 extra flit ignored");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule